// File: doc/BRIEF.md
# Operand Dependency Interlock and Forwarding Controller

This block steers the operand path of a five-stage in-order pipeline. The stages are fetch, operand read, execute, memory and writeback. The controller keeps a small shadow of each stage's control fields: a valid flag, the destination register, the source registers and the execute latency. It checks each source register of the instruction in the operand-read stage against the destinations of the three older instructions. From that check it picks where each operand comes from. When the value cannot yet be delivered, it holds the front of the pipeline and lets an empty slot advance.

Which forwarding paths exist is a parameter with one bit per path. A dependence that only an absent path could serve becomes an interlock stall. Execute operations may take several cycles. The execute stage then keeps its instruction and holds everything behind it, while empty slots drain into the memory stage. With the execute path present, a consumer of an N-cycle result waits N-1 cycles.

The bypass mask bits are bit 0 for execute, bit 1 for memory and bit 2 for writeback.

Top module: `hazard_ctl`

## Requirements
- R1: Only read-after-write dependences cause forwarding or stalls. An instruction that writes a register read by an older instruction, or written by an older instruction, is never delayed by that.
- R2: Each operand has its own 2-bit select, computed independently of the other operand. The encoding is 00 register file, 01 execute result, 10 memory stage, 11 writeback stage.
- R3: When several older instructions write the matching register, the youngest one wins. The search order is execute, then memory, then writeback.
- R4: A source or destination of register 0, an empty operand-read slot and an empty older stage never match. None of them forwards or stalls.
- R5: With the execute path present, a consumer directly behind a single-cycle producer does not stall. It takes the select 01.
- R6: While the execute instruction has more than one latency cycle left, all of the following hold:
  - en_exec, en_read and en_fetch are low.
  - bubble_mem is high.
  - The execute stage counts down its latency.
  - A dependent consumer therefore waits latency-1 cycles when the execute path exists.
- R7: When the youngest match sits in execute or memory and that path is absent, or the match is an unfinished execute result, the block stalls:
  - en_fetch and en_read go low.
  - en_exec stays high.
  - bubble_exec goes high, so the execute stage becomes empty on the next edge.
  - The operand-read contents stay unchanged.
- R8: A match in writeback with no writeback path reads the register file (select 00) without stalling, because a write is visible to a read in the same cycle. With no paths at all, a consumer directly behind a single-cycle producer stalls exactly 2 cycles.
- R9: After reset all stages are empty. Both selects are 00, all enables are high and both bubble signals are low.
- R10: A latency field of 0 or 1 both mean a single-cycle execute operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched instruction present |
| in_rd | input | REG_W | Destination register of fetched instruction (0 = none) |
| in_rs1 | input | REG_W | First source register (0 = unused) |
| in_rs2 | input | REG_W | Second source register (0 = unused) |
| in_lat | input | LAT_W | Execute latency in cycles |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| en_fetch | output | 1 | Fetch stage advance enable |
| en_read | output | 1 | Operand-read stage advance enable |
| en_exec | output | 1 | Execute stage advance enable |
| bubble_exec | output | 1 | Load an empty slot into execute |
| bubble_mem | output | 1 | Load an empty slot into memory |

## Verification
Three instances are driven with the same short programs: all paths, no paths, and execute plus writeback only. Each program places a producer and its consumer at distance 1, 2 or 3. The stall count per instance separates the forwarding cases:
- Distance 1 separates the execute path from none.
- Distance 2 exposes the missing memory path.
- Distance 3 shows the writeback case needing no path.

Further programs cover the remaining behaviour:
- A 3-cycle producer separates the latency-1 wait from a longer interlock.
- Register 0 checks that it never matches.
- Two writers of one register check the youngest-first choice.
- Reversed dependences check that they are ignored.
- A latency field of 0 checks that it acts as 1.

A behavioural model compares every select and enable on each cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_EX  = 2'b01,
      SEL_MEM = 2'b10,
      SEL_WB  = 2'b11
   } fwd_sel_e;

   localparam int PATH_EX  = 0;
   localparam int PATH_MEM = 1;
   localparam int PATH_WB  = 2;
endpackage

// File: rtl/hz_track.sv
module hz_track #(
   parameter int REG_W = 5,
   parameter int LAT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [REG_W-1:0] in_rd,
   input  logic [REG_W-1:0] in_rs1,
   input  logic [REG_W-1:0] in_rs2,
   input  logic [LAT_W-1:0] in_lat,
   input  logic             en_read,
   input  logic             en_exec,
   input  logic             bubble_exec,
   input  logic             bubble_mem,
   output logic             r_valid,
   output logic [REG_W-1:0] r_rs1,
   output logic [REG_W-1:0] r_rs2,
   output logic             x_valid,
   output logic [REG_W-1:0] x_rd,
   output logic             x_busy,
   output logic             m_valid,
   output logic [REG_W-1:0] m_rd,
   output logic             w_valid,
   output logic [REG_W-1:0] w_rd
);
   localparam logic [LAT_W-1:0] ONE_CYC = LAT_W'(1);

   logic [REG_W-1:0] r_rd;
   logic [LAT_W-1:0] r_lat;
   logic [LAT_W-1:0] x_rem;
   logic [LAT_W-1:0] r_lat_eff;

   assign r_lat_eff = (r_lat == '0) ? ONE_CYC : r_lat;
   assign x_busy    = x_valid && (x_rem > ONE_CYC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_valid <= 1'b0;
         r_rd    <= '0;
         r_rs1   <= '0;
         r_rs2   <= '0;
         r_lat   <= '0;
      end else if (en_read) begin
         r_valid <= in_valid;
         r_rd    <= in_rd;
         r_rs1   <= in_rs1;
         r_rs2   <= in_rs2;
         r_lat   <= in_lat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_valid <= 1'b0;
         x_rd    <= '0;
         x_rem   <= '0;
      end else if (!en_exec) begin
         x_rem   <= x_rem - ONE_CYC;
      end else if (bubble_exec) begin
         x_valid <= 1'b0;
         x_rd    <= '0;
         x_rem   <= '0;
      end else begin
         x_valid <= r_valid;
         x_rd    <= r_rd;
         x_rem   <= r_lat_eff;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_rd    <= '0;
         w_valid <= 1'b0;
         w_rd    <= '0;
      end else begin
         m_valid <= bubble_mem ? 1'b0 : x_valid;
         m_rd    <= bubble_mem ? '0 : x_rd;
         w_valid <= m_valid;
         w_rd    <= m_rd;
      end
   end
endmodule

// File: rtl/hz_opsel.sv
module hz_opsel
   import hz_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter bit USE_EX  = 1'b1,
   parameter bit USE_MEM = 1'b1,
   parameter bit USE_WB  = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic             r_valid,
   input  logic             x_valid,
   input  logic [REG_W-1:0] x_rd,
   input  logic             x_busy,
   input  logic             m_valid,
   input  logic [REG_W-1:0] m_rd,
   input  logic             w_valid,
   input  logic [REG_W-1:0] w_rd,
   output logic [1:0]       sel,
   output logic             need_stall
);
   logic hit_x, hit_m, hit_w;
   logic ok_x, ok_m;
   fwd_sel_e wb_choice;
   fwd_sel_e pick;
   logic     block;

   assign hit_x = x_valid && (src != '0) && (x_rd == src);
   assign hit_m = m_valid && (src != '0) && (m_rd == src);
   assign hit_w = w_valid && (src != '0) && (w_rd == src);

   if (USE_EX) begin : g_ex_on
      assign ok_x = !x_busy;
   end else begin : g_ex_off
      assign ok_x = 1'b0;
   end

   if (USE_MEM) begin : g_mem_on
      assign ok_m = 1'b1;
   end else begin : g_mem_off
      assign ok_m = 1'b0;
   end

   if (USE_WB) begin : g_wb_on
      assign wb_choice = SEL_WB;
   end else begin : g_wb_off
      assign wb_choice = SEL_RF;
   end

   always_comb begin
      pick  = SEL_RF;
      block = 1'b0;
      if (hit_x) begin
         pick  = ok_x ? SEL_EX : SEL_RF;
         block = !ok_x;
      end else if (hit_m) begin
         pick  = ok_m ? SEL_MEM : SEL_RF;
         block = !ok_m;
      end else if (hit_w) begin
         pick  = wb_choice;
      end
   end

   assign sel        = r_valid ? pick : SEL_RF;
   assign need_stall = r_valid && block;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
   import hz_pkg::*;
#(
   parameter int       REG_W  = 5,
   parameter int       LAT_W  = 3,
   parameter bit [2:0] BYPASS = 3'b111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [REG_W-1:0] in_rd,
   input  logic [REG_W-1:0] in_rs1,
   input  logic [REG_W-1:0] in_rs2,
   input  logic [LAT_W-1:0] in_lat,
   output logic [1:0]       sel_a,
   output logic [1:0]       sel_b,
   output logic             en_fetch,
   output logic             en_read,
   output logic             en_exec,
   output logic             bubble_exec,
   output logic             bubble_mem
);
   localparam bit HAS_EX  = BYPASS[PATH_EX];
   localparam bit HAS_MEM = BYPASS[PATH_MEM];
   localparam bit HAS_WB  = BYPASS[PATH_WB];

   if (REG_W < 1 || REG_W > 8) begin : g_chk_reg
      $error("hazard_ctl: REG_W out of range");
   end
   if (LAT_W < 1 || LAT_W > 8) begin : g_chk_lat
      $error("hazard_ctl: LAT_W out of range");
   end

   logic             r_valid;
   logic [REG_W-1:0] r_rs1, r_rs2;
   logic             x_valid, x_busy, m_valid, w_valid;
   logic [REG_W-1:0] x_rd, m_rd, w_rd;
   logic [REG_W-1:0] srcs [2];
   logic [1:0]       sels [2];
   logic [1:0]       stl;
   logic             hazard;

   hz_track #(.REG_W(REG_W), .LAT_W(LAT_W)) u_track (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_lat(in_lat),
      .en_read(en_read), .en_exec(en_exec),
      .bubble_exec(bubble_exec), .bubble_mem(bubble_mem),
      .r_valid(r_valid), .r_rs1(r_rs1), .r_rs2(r_rs2),
      .x_valid(x_valid), .x_rd(x_rd), .x_busy(x_busy),
      .m_valid(m_valid), .m_rd(m_rd), .w_valid(w_valid), .w_rd(w_rd)
   );

   assign srcs[0] = r_rs1;
   assign srcs[1] = r_rs2;

   for (genvar g = 0; g < 2; g++) begin : g_op
      hz_opsel #(.REG_W(REG_W), .USE_EX(HAS_EX), .USE_MEM(HAS_MEM), .USE_WB(HAS_WB)) u_sel (
         .src(srcs[g]), .r_valid(r_valid),
         .x_valid(x_valid), .x_rd(x_rd), .x_busy(x_busy),
         .m_valid(m_valid), .m_rd(m_rd), .w_valid(w_valid), .w_rd(w_rd),
         .sel(sels[g]), .need_stall(stl[g])
      );
   end

   assign hazard      = |stl;
   assign sel_a       = sels[0];
   assign sel_b       = sels[1];
   assign en_exec     = !x_busy;
   assign en_read     = !(hazard || x_busy);
   assign en_fetch    = en_read;
   assign bubble_exec = hazard && !x_busy;
   assign bubble_mem  = x_busy;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
   parameter int REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       sel_a,
   input logic [1:0]       sel_b,
   input logic             en_read,
   input logic             en_exec,
   input logic             bubble_exec,
   input logic             bubble_mem,
   input logic [REG_W-1:0] r_rs1,
   input logic [REG_W-1:0] r_rs2,
   input logic             x_valid
);
   AST_EX_FWD_DONE_A: assert property (@(posedge clk) disable iff (!rst_n) (sel_a == 2'b01) |-> en_exec); // R6
   AST_EX_FWD_DONE_B: assert property (@(posedge clk) disable iff (!rst_n) (sel_b == 2'b01) |-> en_exec); // R6
   AST_R0_NO_FWD_A: assert property (@(posedge clk) disable iff (!rst_n) (r_rs1 == '0) |-> (sel_a == 2'b00)); // R4
   AST_R0_NO_FWD_B: assert property (@(posedge clk) disable iff (!rst_n) (r_rs2 == '0) |-> (sel_b == 2'b00)); // R4
   AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !en_read |=> ($stable(r_rs1) && $stable(r_rs2))); // R7
   AST_BUBBLE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n) bubble_exec |=> !x_valid); // R7
   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) !en_exec |-> (bubble_mem && !en_read)); // R6
   AST_BUBBLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bubble_exec && bubble_mem)); // R7
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
   .en_read(en_read), .en_exec(en_exec),
   .bubble_exec(bubble_exec), .bubble_mem(bubble_mem),
   .r_rs1(r_rs1), .r_rs2(r_rs2), .x_valid(x_valid)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       i_v   [3];
   logic [4:0] i_rd  [3];
   logic [4:0] i_rs1 [3];
   logic [4:0] i_rs2 [3];
   logic [2:0] i_lat [3];
   logic [1:0] d_sa  [3];
   logic [1:0] d_sb  [3];
   logic       d_ef  [3];
   logic       d_er  [3];
   logic       d_ee  [3];
   logic       d_bx  [3];
   logic       d_bm  [3];

   hazard_ctl #(.BYPASS(3'b111)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(i_v[0]), .in_rd(i_rd[0]), .in_rs1(i_rs1[0]),
      .in_rs2(i_rs2[0]), .in_lat(i_lat[0]), .sel_a(d_sa[0]), .sel_b(d_sb[0]),
      .en_fetch(d_ef[0]), .en_read(d_er[0]), .en_exec(d_ee[0]),
      .bubble_exec(d_bx[0]), .bubble_mem(d_bm[0]));
   hazard_ctl #(.BYPASS(3'b000)) u_dut_none (
      .clk(clk), .rst_n(rst_n), .in_valid(i_v[1]), .in_rd(i_rd[1]), .in_rs1(i_rs1[1]),
      .in_rs2(i_rs2[1]), .in_lat(i_lat[1]), .sel_a(d_sa[1]), .sel_b(d_sb[1]),
      .en_fetch(d_ef[1]), .en_read(d_er[1]), .en_exec(d_ee[1]),
      .bubble_exec(d_bx[1]), .bubble_mem(d_bm[1]));
   hazard_ctl #(.BYPASS(3'b101)) u_dut_part (
      .clk(clk), .rst_n(rst_n), .in_valid(i_v[2]), .in_rd(i_rd[2]), .in_rs1(i_rs1[2]),
      .in_rs2(i_rs2[2]), .in_lat(i_lat[2]), .sel_a(d_sa[2]), .sel_b(d_sb[2]),
      .en_fetch(d_ef[2]), .en_read(d_er[2]), .en_exec(d_ee[2]),
      .bubble_exec(d_bx[2]), .bubble_mem(d_bm[2]));

   bit [2:0] masks [3] = '{3'b111, 3'b000, 3'b101};

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // behavioural model state, one set per configuration
   int rv[3], rs1[3], rs2[3], rrd[3], rlat[3];
   int xv[3], xrd[3], xrem[3], mv[3], mrd[3], wv[3], wrd[3];

   // program
   int p_rd[16], p_rs1[16], p_rs2[16], p_lat[16];
   int plen;
   int pc[3];
   int stalls[3];

   task automatic report(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 3; c++) begin
         rv[c] = 0; rs1[c] = 0; rs2[c] = 0; rrd[c] = 0; rlat[c] = 0;
         xv[c] = 0; xrd[c] = 0; xrem[c] = 0; mv[c] = 0; mrd[c] = 0; wv[c] = 0; wrd[c] = 0;
      end
   endtask

   task automatic op_eval(int c, int src, output int sel, output int stl);
      int pv[3], prd[3];
      bit busy;
      pv[0] = xv[c]; prd[0] = xrd[c];
      pv[1] = mv[c]; prd[1] = mrd[c];
      pv[2] = wv[c]; prd[2] = wrd[c];
      busy = (xv[c] != 0) && (xrem[c] > 1);
      sel = 0; stl = 0;
      if (rv[c] == 0 || src == 0) return;
      for (int k = 0; k < 3; k++) begin
         if (pv[k] != 0 && prd[k] == src) begin
            if (k == 2) sel = masks[c][2] ? 3 : 0;
            else if (masks[c][k] && !(k == 0 && busy)) sel = k + 1;
            else stl = 1;
            return;
         end
      end
   endtask

   task automatic model_eval(int c, output int sa, output int sb, output int er,
                             output int ee, output int bx, output int bm);
      int s1, s2;
      bit busy;
      op_eval(c, rs1[c], sa, s1);
      op_eval(c, rs2[c], sb, s2);
      busy = (xv[c] != 0) && (xrem[c] > 1);
      ee = busy ? 0 : 1;
      er = (busy || s1 != 0 || s2 != 0) ? 0 : 1;
      bx = (!busy && (s1 != 0 || s2 != 0)) ? 1 : 0;
      bm = busy ? 1 : 0;
   endtask

   task automatic model_step(int c, int er, int ee, int bx, int bm);
      wv[c] = mv[c]; wrd[c] = mrd[c];
      mv[c] = bm ? 0 : xv[c]; mrd[c] = bm ? 0 : xrd[c];
      if (!ee) xrem[c] = xrem[c] - 1;
      else if (bx) begin xv[c] = 0; xrd[c] = 0; xrem[c] = 0; end
      else begin xv[c] = rv[c]; xrd[c] = rrd[c]; xrem[c] = (rlat[c] < 1) ? 1 : rlat[c]; end
      if (er) begin
         rv[c] = i_v[c]; rrd[c] = i_rd[c]; rs1[c] = i_rs1[c]; rs2[c] = i_rs2[c]; rlat[c] = i_lat[c];
      end
   endtask

   task automatic drive_inputs();
      for (int c = 0; c < 3; c++) begin
         if (pc[c] < plen) begin
            i_v[c] = 1'b1; i_rd[c] = 5'(p_rd[pc[c]]); i_rs1[c] = 5'(p_rs1[pc[c]]);
            i_rs2[c] = 5'(p_rs2[pc[c]]); i_lat[c] = 3'(p_lat[pc[c]]);
         end else begin
            i_v[c] = 1'b0; i_rd[c] = '0; i_rs1[c] = '0; i_rs2[c] = '0; i_lat[c] = '0;
         end
      end
   endtask

   task automatic cycle();
      int sa, sb, er, ee, bx, bm;
      @(negedge clk);
      drive_inputs();
      #1;
      for (int c = 0; c < 3; c++) begin
         model_eval(c, sa, sb, er, ee, bx, bm);
         report("R2", $sformatf("cfg%0d sel_a", c), d_sa[c], sa);
         report("R2", $sformatf("cfg%0d sel_b", c), d_sb[c], sb);
         report("R7", $sformatf("cfg%0d en_read", c), d_er[c], er);
         report("R7", $sformatf("cfg%0d en_fetch", c), d_ef[c], er);
         report("R6", $sformatf("cfg%0d en_exec", c), d_ee[c], ee);
         report("R7", $sformatf("cfg%0d bubble_exec", c), d_bx[c], bx);
         report("R6", $sformatf("cfg%0d bubble_mem", c), d_bm[c], bm);
         if (d_er[c] == 1'b0) stalls[c]++;
         model_step(c, er, ee, bx, bm);
         if (er != 0 && pc[c] < plen) pc[c]++;
      end
   endtask

   task automatic add(int rd, int a, int b, int lat);
      p_rd[plen] = rd; p_rs1[plen] = a; p_rs2[plen] = b; p_lat[plen] = lat;
      plen++;
   endtask

   task automatic run_seg(string req, string name, int e_full, int e_none, int e_part);
      int exp[3];
      exp[0] = e_full; exp[1] = e_none; exp[2] = e_part;
      for (int c = 0; c < 3; c++) begin pc[c] = 0; stalls[c] = 0; end
      while (pc[0] < plen || pc[1] < plen || pc[2] < plen) cycle();
      repeat (8) cycle();
      for (int c = 0; c < 3; c++)
         report(req, $sformatf("%s stall cycles cfg%0d", name, c), stalls[c], exp[c]);
      plen = 0;
   endtask

   initial begin : watchdog
      while (cyc < 50000) begin
         @(posedge clk);
         cyc++;
      end
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      plen = 0;
      for (int c = 0; c < 3; c++) pc[c] = 0;
      drive_inputs();
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state
      for (int c = 0; c < 3; c++) begin
         report("R9", "reset sel_a", d_sa[c], 0);
         report("R9", "reset sel_b", d_sb[c], 0);
         report("R9", "reset en_read", d_er[c], 1);
         report("R9", "reset en_exec", d_ee[c], 1);
         report("R9", "reset bubbles", {d_bx[c], d_bm[c]}, 0);
      end

      // R5: single-cycle producer, consumer at distance 1
      add(1, 2, 3, 1); add(4, 1, 5, 1);
      run_seg("R5", "dist1", 0, 2, 0);
      // R8 / R7: distance 2, missing memory path stalls the partial config
      add(1, 2, 3, 1); add(9, 10, 11, 1); add(4, 6, 1, 1);
      run_seg("R7", "dist2", 0, 1, 1);
      // R8: distance 3 needs no path
      add(1, 2, 3, 1); add(9, 10, 11, 1); add(12, 10, 11, 1); add(4, 1, 1, 1);
      run_seg("R8", "dist3", 0, 0, 0);
      // R6: 3-cycle producer then dependent consumer
      add(3, 2, 1, 3); add(4, 3, 2, 1);
      run_seg("R6", "mul3", 2, 4, 2);
      // R4: register 0 never matches
      add(0, 2, 3, 1); add(4, 0, 0, 1);
      run_seg("R4", "reg0", 0, 0, 0);
      // R3: two writers of r5, youngest wins
      add(5, 2, 3, 1); add(5, 6, 7, 1); add(8, 5, 5, 1);
      run_seg("R3", "youngest", 0, 2, 0);
      // R1: write-after-read and write-after-write do not stall
      add(7, 1, 2, 1); add(1, 3, 4, 1); add(1, 5, 6, 1);
      run_seg("R1", "war_waw", 0, 0, 0);
      // R10: latency field 0 acts as one cycle
      add(6, 2, 3, 0); add(4, 6, 2, 1);
      run_seg("R10", "lat0", 0, 2, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule